// File: doc/BRIEF.md
# Two-Wire Potentiometer Command Front End

This block is the slave end of a two-wire serial bus (clock SCL, open-drain data SDA) that sits in front of a digital potentiometer register engine. It oversamples both bus lines with the system clock and detects START and STOP conditions. A transaction opens with an address byte. When that byte matches, the block decodes the instruction byte that follows. Depending on the opcode it then issues one command strobe to the register engine, collects one write byte, returns one read byte, or enters a stepping mode. In stepping mode every SCL high pulse becomes one up or down step of the selected wiper.

The register engine receives `cmd_valid` together with the opcode, the data-register select, the pot select and, for writes, the data byte. For reads it must present `rd_data` for the latched select; the block samples `rd_data` in the clock cycle just before `cmd_valid` rises. Step requests arrive as one-cycle `step_pulse` strobes, with `step_up` giving the direction. Keeping the wiper within its range is the engine's job.

The control state machine has seven states:
- IDLE: the bus is free.
- DEVADDR: the address byte is shifted in and acknowledged.
- INSTR: the instruction byte is shifted in and acknowledged.
- WDATA: a write data byte is received.
- RDATA: a read byte is sent.
- STEP: free-running increment/decrement.
- IGNORE: the bus is not addressed to this slave, or the command is complete.

Transitions:
- START moves any state to DEVADDR.
- STOP moves any state to IDLE.
- DEVADDR moves to INSTR after an acknowledged match. On a mismatch it moves to IGNORE.
- INSTR moves to IGNORE (transfer opcodes, or a rejected instruction), to WDATA (write opcodes), to RDATA (read opcodes) or to STEP (step opcode).
- WDATA and RDATA move to IGNORE when the slot after their byte closes.

Top module: `potcmd_frontend`

## Requirements
- R1: While reset is held, and right after it is released, `sda_oe`, `cmd_valid` and `step_pulse` are all 0.
- R2: The byte after START is acknowledged only when its upper nibble equals DEV_ID (default binary 0101) and its lower nibble equals `addr_pins`. An acknowledge means `sda_oe`=1 for the whole ninth SCL high phase. On any other value the slave gives no acknowledge and produces no strobe, step or bus drive until the next START.
- R3: The instruction byte is sent MSB first and laid out as [7:4] opcode, [3:2] register select, [1] must be 0, [0] pot select. Only the opcodes listed in R4 to R7 with bit 1 equal to 0 are acknowledged. Any other byte gets no acknowledge and produces no strobe.
- R4: The transfer opcodes are 1101 (one register into the wiper), 1110 (wiper into one register), 0001 (global register into wipers) and 1000 (global wipers into register). Each gives exactly one `cmd_valid`, carrying opcode, register select and pot select, after the instruction acknowledge. Any later byte is not acknowledged.
- R5: The write opcodes are 1010 (wiper register) and 1100 (data register). A third byte is received MSB first and acknowledged. Then exactly one `cmd_valid` is issued, with `cmd_data` equal to that byte.
- R6: The read opcodes are 1001 (wiper register) and 1011 (data register). Each gives one `cmd_valid` after the instruction acknowledge. The byte on `rd_data` is then sent MSB first, with `sda_oe`=1 meaning a 0 bit, and `sda_oe` is 0 during the master's acknowledge slot.
- R7: After opcode 0010 is acknowledged, every SCL high pulse produces exactly one `step_pulse` when SCL falls. `step_up` equals the SDA level at the rising edge of that pulse (1 means toward the high terminal).
- R8: Stepping continues for any number of pulses until STOP. The SCL high phase that carries the STOP gives no step, and SCL pulses after the STOP give none.
- R9: A START or STOP before the eighth bit of a byte has been clocked aborts the command, and no `cmd_valid` is issued for it.
- R10: A repeated START at any point restarts address decoding, and a complete command that follows it is executed normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, well above the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| addr_pins | input | 4 | Hardware address strapping |
| rd_data | input | 8 | Read byte from the register engine for the latched select |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge or a 0 read bit) |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_op | output | 4 | Latched opcode |
| cmd_reg | output | 2 | Latched data-register select |
| cmd_pot | output | 1 | Latched pot select |
| cmd_data | output | 8 | Write byte, valid with cmd_valid for write opcodes |
| step_pulse | output | 1 | One-cycle wiper step request |
| step_up | output | 1 | Step direction, valid with step_pulse |

## Verification
A wrong state or a slipped bit count first shows at the port as a missing or misplaced acknowledge. That slot is the ninth SCL high phase of the byte concerned, so the fault is visible within one byte time. A wrongly decoded opcode class shows as an extra strobe, a missing strobe or wrong strobe fields. It appears within a few system clocks of the SCL fall that closes the instruction acknowledge, or the data acknowledge for writes. A stepping state that is left too late or too early shows as a step after STOP or a missing step on the next SCL pulse. A corrupted read shift register shows on the bit slot that is wrong.

// File: rtl/potcmd_pkg.sv
package potcmd_pkg;

    localparam int DATA_W   = 8;
    localparam int NIB_W    = 4;
    localparam int CNT_W    = $clog2(DATA_W + 2);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_INSTR,
        ST_WDATA,
        ST_RDATA,
        ST_STEP,
        ST_IGNORE
    } fe_state_t;

    typedef enum logic [2:0] {
        CL_BAD,
        CL_XFER,
        CL_WRITE,
        CL_READ,
        CL_STEP
    } op_class_t;

    localparam logic [NIB_W-1:0] OP_RD_WIPER  = 4'b1001;
    localparam logic [NIB_W-1:0] OP_WR_WIPER  = 4'b1010;
    localparam logic [NIB_W-1:0] OP_RD_DREG   = 4'b1011;
    localparam logic [NIB_W-1:0] OP_WR_DREG   = 4'b1100;
    localparam logic [NIB_W-1:0] OP_DREG2WIP  = 4'b1101;
    localparam logic [NIB_W-1:0] OP_WIP2DREG  = 4'b1110;
    localparam logic [NIB_W-1:0] OP_GL_D2W    = 4'b0001;
    localparam logic [NIB_W-1:0] OP_GL_W2D    = 4'b1000;
    localparam logic [NIB_W-1:0] OP_STEP      = 4'b0010;

    function automatic op_class_t classify(input logic [NIB_W-1:0] op);
        op_class_t c;
        case (op)
            OP_DREG2WIP, OP_WIP2DREG, OP_GL_D2W, OP_GL_W2D: c = CL_XFER;
            OP_WR_WIPER, OP_WR_DREG:                        c = CL_WRITE;
            OP_RD_WIPER, OP_RD_DREG:                        c = CL_READ;
            OP_STEP:                                        c = CL_STEP;
            default:                                        c = CL_BAD;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/potcmd_bus_sampler.sv
module potcmd_bus_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_q;
    logic              sda_q;
    logic              scl_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_q  <= scl_lvl;
            sda_q  <= sda_lvl;
        end
    end

    assign scl_lvl   = scl_sh[STAGES-1];
    assign sda_lvl   = sda_sh[STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_q;
    assign scl_fall  = ~scl_lvl & scl_q;
    assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;

endmodule

// File: rtl/potcmd_ctrl.sv
module potcmd_ctrl
    import potcmd_pkg::*;
#(
    parameter logic [NIB_W-1:0] DEV_ID = 4'b0101
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sda_lvl,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic [NIB_W-1:0]   addr_pins,
    input  logic [DATA_W-1:0]  rd_data,
    output logic               sda_oe,
    output logic               cmd_valid,
    output logic [NIB_W-1:0]   cmd_op,
    output logic [1:0]         cmd_reg,
    output logic               cmd_pot,
    output logic [DATA_W-1:0]  cmd_data,
    output logic               step_pulse,
    output logic               step_up
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(DATA_W + 1);

    fe_state_t         state, state_nx;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] shreg;
    logic              step_dir;
    logic              byte_ok;
    logic              byte_done;
    logic              slot_end;
    op_class_t         cls_new, cls_held;

    assign byte_done = scl_fall && (cnt == CNT_FULL);
    assign slot_end  = scl_fall && (cnt == CNT_ACK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        cls_new  = classify(shreg[7:4]);
        cls_held = classify(cmd_op);
        byte_ok  = 1'b0;
        state_nx = state;
        unique case (state)
            ST_DEVADDR: byte_ok = (shreg == {DEV_ID, addr_pins});
            ST_INSTR:   byte_ok = (cls_new != CL_BAD) && !shreg[1];
            ST_WDATA:   byte_ok = 1'b1;
            ST_IDLE, ST_RDATA, ST_STEP, ST_IGNORE: byte_ok = 1'b0;
        endcase
        if (start_det) begin
            state_nx = ST_DEVADDR;
        end else if (stop_det) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_DEVADDR: begin
                    if (byte_done && !byte_ok) state_nx = ST_IGNORE;
                    else if (slot_end)         state_nx = ST_INSTR;
                end
                ST_INSTR: begin
                    if (byte_done && !byte_ok) state_nx = ST_IGNORE;
                    else if (slot_end) begin
                        unique case (cls_held)
                            CL_WRITE:        state_nx = ST_WDATA;
                            CL_READ:         state_nx = ST_RDATA;
                            CL_STEP:         state_nx = ST_STEP;
                            CL_XFER, CL_BAD: state_nx = ST_IGNORE;
                        endcase
                    end
                end
                ST_WDATA, ST_RDATA: if (slot_end) state_nx = ST_IGNORE;
                ST_IDLE, ST_STEP, ST_IGNORE: state_nx = state;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt        <= '0;
            shreg      <= '0;
            sda_oe     <= 1'b0;
            cmd_valid  <= 1'b0;
            cmd_op     <= '0;
            cmd_reg    <= '0;
            cmd_pot    <= 1'b0;
            cmd_data   <= '0;
            step_pulse <= 1'b0;
            step_up    <= 1'b0;
            step_dir   <= 1'b0;
        end else begin
            cmd_valid  <= 1'b0;
            step_pulse <= 1'b0;
            if (start_det || stop_det) begin
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    ST_DEVADDR, ST_INSTR, ST_WDATA: begin
                        if (scl_rise && cnt < CNT_FULL) begin
                            shreg <= {shreg[DATA_W-2:0], sda_lvl};
                            cnt   <= cnt + 1'b1;
                        end
                        if (byte_done) begin
                            cnt    <= CNT_ACK;
                            sda_oe <= byte_ok;
                            if (state == ST_INSTR) begin
                                cmd_op  <= shreg[7:4];
                                cmd_reg <= shreg[3:2];
                                cmd_pot <= shreg[0];
                            end
                            if (state == ST_WDATA) cmd_data <= shreg;
                        end
                        if (slot_end) begin
                            cnt    <= '0;
                            sda_oe <= 1'b0;
                            if (state == ST_WDATA) cmd_valid <= 1'b1;
                            if (state == ST_INSTR &&
                                (cls_held == CL_XFER || cls_held == CL_READ))
                                cmd_valid <= 1'b1;
                            if (state == ST_INSTR && cls_held == CL_READ) begin
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[DATA_W-1];
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise && cnt < CNT_FULL) cnt <= cnt + 1'b1;
                        if (scl_fall && cnt != '0 && cnt < CNT_FULL) begin
                            shreg  <= {shreg[DATA_W-2:0], 1'b0};
                            sda_oe <= ~shreg[DATA_W-2];
                        end
                        if (byte_done) begin
                            sda_oe <= 1'b0;
                            cnt    <= CNT_ACK;
                        end
                        if (slot_end) cnt <= '0;
                    end
                    ST_STEP: begin
                        if (scl_rise) step_dir <= sda_lvl;
                        if (scl_fall) begin
                            step_pulse <= 1'b1;
                            step_up    <= step_dir;
                        end
                    end
                    ST_IDLE, ST_IGNORE: sda_oe <= 1'b0;
                endcase
            end
        end
    end

endmodule

// File: rtl/potcmd_frontend.sv
module potcmd_frontend
    import potcmd_pkg::*;
#(
    parameter logic [NIB_W-1:0] DEV_ID      = 4'b0101,
    parameter int               SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [NIB_W-1:0]   addr_pins,
    input  logic [DATA_W-1:0]  rd_data,
    output logic               sda_oe,
    output logic               cmd_valid,
    output logic [NIB_W-1:0]   cmd_op,
    output logic [1:0]         cmd_reg,
    output logic               cmd_pot,
    output logic [DATA_W-1:0]  cmd_data,
    output logic               step_pulse,
    output logic               step_up
);

    logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;

    potcmd_bus_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    potcmd_ctrl #(.DEV_ID(DEV_ID)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_lvl    (sda_lvl),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .addr_pins  (addr_pins),
        .rd_data    (rd_data),
        .sda_oe     (sda_oe),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_reg    (cmd_reg),
        .cmd_pot    (cmd_pot),
        .cmd_data   (cmd_data),
        .step_pulse (step_pulse),
        .step_up    (step_up)
    );

endmodule

// File: rtl/potcmd_checker.sv
module potcmd_checker (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_oe,
    input logic cmd_valid,
    input logic step_pulse
);

    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_quiet: assert (!sda_oe && !cmd_valid && !step_pulse);
        end
    end

    a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    a_r7_step_single: assert property (@(posedge clk) disable iff (!rst_n)
        step_pulse |=> !step_pulse);

    a_r7_step_not_with_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && step_pulse));

    a_r6_drive_change_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) || $fell(sda_oe)) |-> !scl_i);

endmodule

bind potcmd_frontend potcmd_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_oe     (sda_oe),
    .cmd_valid  (cmd_valid),
    .step_pulse (step_pulse)
);

// File: tb/tb_potcmd_frontend.sv
module tb_potcmd_frontend;

    localparam int H = 16;
    localparam logic [3:0] PINS = 4'h6;
    localparam logic [7:0] ADDR_OK = {4'b0101, PINS};

    typedef struct packed {
        logic       stp;
        logic       up;
        logic [3:0] op;
        logic [1:0] rg;
        logic       pot;
        logic [7:0] dat;
        logic       chk_dat;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [7:0] rd_val = 8'h00;
    logic sda_oe, cmd_valid, cmd_pot, step_pulse, step_up;
    logic [3:0] cmd_op;
    logic [1:0] cmd_reg;
    logic [7:0] cmd_data;
    wire  sda_bus = sda_m & ~sda_oe;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R1";
    exp_t q[$];

    always #4 clk = ~clk;

    potcmd_frontend dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .addr_pins(PINS), .rd_data(rd_val), .sda_oe(sda_oe),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_reg(cmd_reg),
        .cmd_pot(cmd_pot), .cmd_data(cmd_data),
        .step_pulse(step_pulse), .step_up(step_up)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && (cmd_valid || step_pulse)) begin
            if (q.size() == 0) begin
                check(1'b0, {cur_req, " unexpected strobe"},
                      {cmd_valid, step_pulse, cmd_op}, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (e.stp)
                    check(step_pulse && !cmd_valid && step_up == e.up,
                          {cur_req, " step"}, {step_pulse, step_up}, {1'b1, e.up});
                else
                    check(cmd_valid && !step_pulse && cmd_op == e.op &&
                          cmd_reg == e.rg && cmd_pot == e.pot &&
                          (!e.chk_dat || cmd_data == e.dat),
                          {cur_req, " command"},
                          {cmd_op, cmd_reg, cmd_pot, cmd_data},
                          {e.op, e.rg, e.pot, e.dat});
            end
        end
    end

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; w(H/2); scl_m = 1'b1; w(H);
        sda_m = 1'b0; w(H); scl_m = 1'b0; w(H/2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; w(H/2); scl_m = 1'b1; w(H);
        sda_m = 1'b1; w(H);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; w(H/2); scl_m = 1'b1; w(H); scl_m = 1'b0; w(H/2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ackd);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        sda_m = 1'b1; w(H/2); scl_m = 1'b1; w(H/2);
        ackd = !sda_bus;
        w(H/2); scl_m = 1'b0; w(H/2);
    endtask

    task automatic read_byte(output logic [7:0] d);
        d = '0;
        for (int i = 0; i < 8; i++) begin
            sda_m = 1'b1; w(H/2); scl_m = 1'b1; w(H/2);
            d = {d[6:0], sda_bus};
            w(H/2); scl_m = 1'b0; w(H/2);
        end
        put_bit(1'b1);
    endtask

    function automatic logic [7:0] ins(input logic [3:0] op, input logic [1:0] rg, input logic p);
        return {op, rg, 1'b0, p};
    endfunction

    function automatic exp_t ecmd(input logic [3:0] op, input logic [1:0] rg,
                                  input logic p, input logic [7:0] d, input logic cd);
        exp_t e;
        e = '{stp:1'b0, up:1'b0, op:op, rg:rg, pot:p, dat:d, chk_dat:cd};
        return e;
    endfunction

    task automatic xfer_cmd(input logic [3:0] op, input logic [1:0] rg, input logic p);
        logic a;
        bus_start();
        send_byte(ADDR_OK, a); check(a, "R2 address ack", a, 1);
        q.push_back(ecmd(op, rg, p, 8'h00, 1'b0));
        send_byte(ins(op, rg, p), a); check(a, "R3 instruction ack", a, 1);
        send_byte(8'hFF, a); check(!a, "R4 extra byte not acked", a, 0);
        bus_stop(); w(H);
    endtask

    task automatic write_cmd(input logic [3:0] op, input logic [1:0] rg,
                             input logic p, input logic [7:0] d);
        logic a;
        bus_start();
        send_byte(ADDR_OK, a); check(a, "R2 address ack", a, 1);
        send_byte(ins(op, rg, p), a); check(a, "R3 instruction ack", a, 1);
        q.push_back(ecmd(op, rg, p, d, 1'b1));
        send_byte(d, a); check(a, "R5 data ack", a, 1);
        bus_stop(); w(H);
    endtask

    task automatic read_cmd(input logic [3:0] op, input logic [1:0] rg,
                            input logic p, input logic [7:0] v);
        logic a;
        logic [7:0] d;
        rd_val = v;
        bus_start();
        send_byte(ADDR_OK, a); check(a, "R2 address ack", a, 1);
        q.push_back(ecmd(op, rg, p, 8'h00, 1'b0));
        send_byte(ins(op, rg, p), a); check(a, "R3 instruction ack", a, 1);
        read_byte(d); check(d == v, "R6 read byte", d, v);
        bus_stop(); w(H);
    endtask

    task automatic step_bit(input logic b);
        exp_t e;
        e = '{stp:1'b1, up:b, op:4'h0, rg:2'b00, pot:1'b0, dat:8'h00, chk_dat:1'b0};
        q.push_back(e);
        put_bit(b);
    endtask

    initial begin
        logic a;
        w(10);
        check(!sda_oe && !cmd_valid && !step_pulse, "R1 in reset",
              {sda_oe, cmd_valid, step_pulse}, 0);
        rst_n = 1'b1;
        w(5);
        check(!sda_oe && !cmd_valid && !step_pulse, "R1 after reset",
              {sda_oe, cmd_valid, step_pulse}, 0);

        cur_req = "R4";
        xfer_cmd(4'b1101, 2'd1, 1'b0);
        xfer_cmd(4'b0001, 2'd3, 1'b1);
        xfer_cmd(4'b1000, 2'd2, 1'b0);
        check(q.size() == 0, "R4 all transfer strobes seen", q.size(), 0);

        cur_req = "R5";
        write_cmd(4'b1010, 2'd0, 1'b1, 8'h3C);
        write_cmd(4'b1100, 2'd2, 1'b0, 8'hC5);
        check(q.size() == 0, "R5 write strobes seen", q.size(), 0);

        cur_req = "R6";
        read_cmd(4'b1011, 2'd2, 1'b1, 8'hA5);
        read_cmd(4'b1001, 2'd0, 1'b0, 8'h5A);
        check(q.size() == 0, "R6 read strobes seen", q.size(), 0);

        cur_req = "R2";
        bus_start();
        send_byte({4'b0101, 4'h7}, a); check(!a, "R2 pin mismatch nack", a, 0);
        send_byte(ins(4'b1101, 2'd0, 1'b0), a); check(!a, "R2 ignored after mismatch", a, 0);
        bus_stop(); w(H);
        bus_start();
        send_byte({4'b1001, PINS}, a); check(!a, "R2 id mismatch nack", a, 0);
        send_byte(ins(4'b1110, 2'd1, 1'b1), a); check(!a, "R2 ignored after bad id", a, 0);
        bus_stop(); w(H);

        cur_req = "R3";
        bus_start();
        send_byte(ADDR_OK, a); check(a, "R3 address ack", a, 1);
        send_byte(ins(4'b0011, 2'd0, 1'b0), a); check(!a, "R3 unknown opcode nack", a, 0);
        bus_stop(); w(H);
        bus_start();
        send_byte(ADDR_OK, a);
        send_byte({4'b1101, 2'b01, 1'b1, 1'b0}, a); check(!a, "R3 bit1 set nack", a, 0);
        bus_stop(); w(H);

        cur_req = "R7";
        bus_start();
        send_byte(ADDR_OK, a);
        send_byte(ins(4'b0010, 2'd0, 1'b1), a); check(a, "R7 step instruction ack", a, 1);
        step_bit(1'b1); step_bit(1'b1); step_bit(1'b0);
        step_bit(1'b1); step_bit(1'b0); step_bit(1'b0);
        cur_req = "R8";
        for (int i = 0; i < 20; i++) step_bit(i[0]);
        bus_stop(); w(H);
        check(q.size() == 0, "R7 steps all seen", q.size(), 0);
        put_bit(1'b1); put_bit(1'b1); w(H);
        check(q.size() == 0, "R8 no step after stop", q.size(), 0);

        cur_req = "R9";
        bus_start();
        send_byte(ADDR_OK, a);
        send_byte(ins(4'b1010, 2'd1, 1'b0), a);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        bus_stop(); w(4*H);
        bus_start();
        send_byte(ADDR_OK, a);
        send_byte(ins(4'b1100, 2'd3, 1'b1), a);
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        cur_req = "R10";
        q.push_back(ecmd(4'b1110, 2'd3, 1'b1, 8'h00, 1'b0));
        bus_start();
        send_byte(ADDR_OK, a); check(a, "R10 address ack after repeated start", a, 1);
        send_byte(ins(4'b1110, 2'd3, 1'b1), a); check(a, "R10 instruction ack", a, 1);
        bus_stop(); w(4*H);
        check(q.size() == 0, "R10 command after repeated start", q.size(), 0);
        check(!sda_oe, "R9 bus released", sda_oe, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog %s actual=timeout expected=done", cur_req);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule